// File: doc/BRIEF.md
# Seeded Serial Transmit Scrambler

This block whitens the encoded transmit symbol stream of a 100 Mb/s copper link before line coding. Symbols arrive one bit per clock, idle and data alike, each qualified by a valid strobe. Each bit is XORed with the output of an 11-bit linear-feedback key generator built on the polynomial x^11 + x^9 + 1. The result is a flat spectrum and lower emissions. A station address strap supplies five bits of the generator seed, and fixed constant bits supply the rest. Two links with different addresses therefore start from different points of the sequence.

A bypass input sends bits through unchanged for test and diagnostics. A speed input turns the scrambler off for the 10 Mb/s mode, where bits also pass through unchanged. The output is registered and has a one-cycle latency. It comes with its own valid flag.

Top module: `stream_scrambler`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_vld` and `out_bit` are 0.
- R2: Reset loads the key register with the seed {FIXED_HI, stn_addr}. The address takes the five low bits, and FIXED_HI (default 6'b101001) takes the six high bits, so the seed is never zero.
- R3: With `fast_mode`=1 and `bypass`=0, each valid bit leaves as `sym_bit` XOR key. The key is bit 10 XOR bit 8 of the register. The register then shifts left by one place and takes the key bit into bit 0.
- R4: `out_vld` equals `sym_vld` of the previous cycle, and `out_bit` carries the result for that bit.
- R5: A cycle with `sym_vld`=0 does not advance the register and leaves `out_bit` unchanged.
- R6: With `bypass`=1 and `fast_mode`=1, each valid bit leaves unchanged, and the register still advances once per valid bit.
- R7: With `fast_mode`=0, each valid bit leaves unchanged, and the register does not advance.
- R8: When `link_up`=0 and `stn_addr` differs from its value in the previous cycle, the register loads the new seed {FIXED_HI, stn_addr}. An address change while `link_up`=1 has no effect.
- R9: When a reload and a valid bit fall in the same cycle, that bit is scrambled with the key of the old register. The register then holds the new seed and does not advance.
- R10: The key register is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | Input bit is valid this cycle |
| sym_bit | input | 1 | Encoded symbol bit |
| stn_addr | input | 5 | Station address strap, forms the low seed bits |
| link_up | input | 1 | Link is up; reseeding on an address change is blocked while this is high |
| fast_mode | input | 1 | 1 selects 100 Mb/s operation, 0 selects 10 Mb/s pass-through |
| bypass | input | 1 | 1 passes bits through unscrambled |
| out_vld | output | 1 | Output bit is valid |
| out_bit | output | 1 | Scrambled or passed-through bit |

## Verification
A change of the station address while the link is down can arrive in the same cycle as a valid symbol bit. In that case the reload and the one-step advance compete for the key register. The bench forces this by changing `stn_addr` with `link_up` low in the same cycle that it presents a valid bit. It then checks that this bit used the old key, and that the bits after it follow the sequence from the new seed with no extra step. Address changes while the link is up are also made during streaming, and the bench confirms that the sequence continues without a break.

// File: rtl/scr_pkg.sv
package scr_pkg;
  function automatic logic lfsr_key(input logic [10:0] st, input int hi, input int lo);
    return st[hi] ^ st[lo];
  endfunction
endpackage

// File: rtl/scr_seed_ctl.sv
module scr_seed_ctl #(
  parameter int LFSR_W = 11,
  parameter int ADDR_W = 5,
  parameter logic [LFSR_W-ADDR_W-1:0] FIXED_HI = 6'b101001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up,
  input  logic [ADDR_W-1:0] stn_addr,
  output logic              load,
  output logic [LFSR_W-1:0] seed
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    addr_q <= stn_addr;
  end

  assign load = rst | (~link_up & (stn_addr != addr_q));
  assign seed = {FIXED_HI, stn_addr};
endmodule

// File: rtl/scr_keygen.sv
module scr_keygen #(
  parameter int LFSR_W = 11,
  parameter int TAP_LO = 8
) (
  input  logic              clk,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              adv,
  output logic [LFSR_W-1:0] state,
  output logic              key
);
  localparam int TAP_HI = LFSR_W - 1;

  assign key = state[TAP_HI] ^ state[TAP_LO];

  always_ff @(posedge clk) begin
    if (load)     state <= seed;
    else if (adv) state <= {state[LFSR_W-2:0], key};
  end
endmodule

// File: rtl/scr_outstage.sv
module scr_outstage (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic din,
  input  logic key,
  input  logic scr_en,
  output logic out_vld,
  output logic out_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= vld;
      if (vld) out_bit <= din ^ (key & scr_en);
    end
  end
endmodule

// File: rtl/stream_scrambler.sv
module stream_scrambler #(
  parameter int LFSR_W = 11,
  parameter int ADDR_W = 5,
  parameter int TAP_LO = 8,
  parameter logic [LFSR_W-ADDR_W-1:0] FIXED_HI = 6'b101001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_vld,
  input  logic              sym_bit,
  input  logic [ADDR_W-1:0] stn_addr,
  input  logic              link_up,
  input  logic              fast_mode,
  input  logic              bypass,
  output logic              out_vld,
  output logic              out_bit
);
  logic              load;
  logic [LFSR_W-1:0] seed;
  logic [LFSR_W-1:0] key_state;
  logic              key;
  logic              adv;
  logic              scr_en;

  assign adv    = sym_vld & fast_mode;
  assign scr_en = fast_mode & ~bypass;

  scr_seed_ctl #(.LFSR_W(LFSR_W), .ADDR_W(ADDR_W), .FIXED_HI(FIXED_HI)) u_seed (
    .clk(clk), .rst(rst), .link_up(link_up), .stn_addr(stn_addr),
    .load(load), .seed(seed)
  );

  scr_keygen #(.LFSR_W(LFSR_W), .TAP_LO(TAP_LO)) u_key (
    .clk(clk), .load(load), .seed(seed), .adv(adv),
    .state(key_state), .key(key)
  );

  scr_outstage u_out (
    .clk(clk), .rst(rst), .vld(sym_vld), .din(sym_bit), .key(key),
    .scr_en(scr_en), .out_vld(out_vld), .out_bit(out_bit)
  );
endmodule

module stream_scrambler_chk #(
  parameter int LFSR_W = 11,
  parameter int ADDR_W = 5,
  parameter logic [LFSR_W-ADDR_W-1:0] FIXED_HI = 6'b101001
) (
  input logic              clk,
  input logic              rst,
  input logic              sym_vld,
  input logic              sym_bit,
  input logic [ADDR_W-1:0] stn_addr,
  input logic              link_up,
  input logic              fast_mode,
  input logic              bypass,
  input logic              out_vld,
  input logic              out_bit,
  input logic [LFSR_W-1:0] state
);
  // R4
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sym_vld |=> out_vld);
  // R4
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_vld |=> !out_vld);
  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_vld |=> $stable(out_bit));
  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && bypass) |=> (out_bit == $past(sym_bit)));
  // R7
  slow_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && !fast_mode) |=> (out_bit == $past(sym_bit)));
  // R8
  reseed_chk: assert property (@(posedge clk) disable iff (rst)
    (!link_up && stn_addr != $past(stn_addr)) |=> (state == {FIXED_HI, $past(stn_addr)}));
  // R10
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

bind stream_scrambler stream_scrambler_chk #(.LFSR_W(LFSR_W), .ADDR_W(ADDR_W), .FIXED_HI(FIXED_HI)) u_chk (
  .clk(clk), .rst(rst), .sym_vld(sym_vld), .sym_bit(sym_bit), .stn_addr(stn_addr),
  .link_up(link_up), .fast_mode(fast_mode), .bypass(bypass),
  .out_vld(out_vld), .out_bit(out_bit), .state(key_state)
);

// File: tb/stream_scrambler_bench.sv
module stream_scrambler_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] FIX = 6'b101001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_vld = 1'b0, sym_bit = 1'b0;
  logic [4:0] stn_addr = 5'h13;
  logic link_up = 1'b0, fast_mode = 1'b1, bypass = 1'b0;
  logic out_vld, out_bit;

  int checks = 0, errors = 0;
  logic [10:0] m;
  logic [4:0] maddr;
  logic mout = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_scrambler u_stream_scrambler (
    .clk(clk), .rst(rst), .sym_vld(sym_vld), .sym_bit(sym_bit), .stn_addr(stn_addr),
    .link_up(link_up), .fast_mode(fast_mode), .bypass(bypass),
    .out_vld(out_vld), .out_bit(out_bit)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model, check at next negedge
  task automatic step(input logic v, input logic b, input string req);
    logic key;
    logic reload;
    sym_vld = v; sym_bit = b;
    key = m[10] ^ m[8];
    reload = !link_up && (stn_addr != maddr);
    if (v) mout = (fast_mode && !bypass) ? (b ^ key) : b;
    if (reload) m = {FIX, stn_addr};
    else if (v && fast_mode) m = {m[9:0], key};
    maddr = stn_addr;
    @(posedge clk); @(negedge clk);
    chk({req, " vld R4"}, out_vld, v);
    chk({req, " bit"}, out_bit, mout);
  endtask

  task automatic t_reset();
    rst = 1'b1; sym_vld = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 vld in reset", out_vld, 1'b0);
    chk("R1 bit in reset", out_bit, 1'b0);
    rst = 1'b0;
    m = {FIX, stn_addr}; maddr = stn_addr; mout = 1'b0;
    step(1'b0, 1'b0, "R1");
  endtask

  task automatic t_seed_stream();
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 24; i++) step(1'b1, i[0], "R3");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, "R3");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 20; i++) step(i % 3 != 0, i[1], "R5");
  endtask

  task automatic t_bypass();
    bypass = 1'b1;
    for (int i = 0; i < 12; i++) step(1'b1, i[0] ^ i[2], "R6");
    bypass = 1'b0;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R6 resume");
  endtask

  task automatic t_slow();
    fast_mode = 1'b0;
    for (int i = 0; i < 12; i++) step(1'b1, i[1], "R7");
    fast_mode = 1'b1;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R7 resume");
  endtask

  task automatic t_reload();
    link_up = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R8 up");
    stn_addr = 5'h0A;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R8 ignored");
    link_up = 1'b0;
    stn_addr = 5'h05;
    step(1'b0, 1'b0, "R8 load");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R8 stream");
    stn_addr = 5'h00;
    step(1'b0, 1'b0, "R8 zero addr");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R8 R10 stream");
  endtask

  task automatic t_collide();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R9 pre");
    stn_addr = 5'h1C;
    step(1'b1, 1'b1, "R9 same cycle");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R9 post");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seed_stream();
    t_gaps();
    t_bypass();
    t_slow();
    t_reload();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule